// File: doc/BRIEF.md
# Accumulator ALU with Program Status Word

This block is the data path of an 8-bit accumulator machine. It holds an accumulator, a companion B register and an 8-bit status word. Each cycle in which `op_valid` is high, it applies one operation selected by `op_code`. The operation can use the accumulator, an 8-bit operand, B and a single Boolean input bit. The results land in the registers on the next clock edge. Arithmetic, logic, rotate, nibble swap, decimal adjust, multiply, divide and the carry-based Boolean operations all share this path. A decoder outside the block supplies the operation code and the operands.

The status word holds, from bit 7 down to bit 0: carry CY, auxiliary carry AC, user flag F0, bank select RS1 and RS0, overflow OV, user flag F1 and parity P. Hardware keeps P in step with the accumulator after every update. The two bank-select bits are turned into a register-bank base address for the register file next to the block. Multiply and divide read B and also write B.

Top module: `acc_alu_core`

## Requirements
- R1: While reset is low, acc, b_reg and psw are 00h and bank_base is 0. The block leaves reset with these values.
- R2: psw bit 0 always equals the XOR of the eight accumulator bits, so the accumulator together with that bit holds an even number of ones.
- R3: bank_base equals the value of psw bits 4:3 times 8, giving 00h, 08h, 10h or 18h. Opcode 29 loads psw bits 7:1 from operand bits 7:1, and P stays hardware-computed.
- R4: Opcode 1 computes A+operand and opcode 2 computes A+operand+CY. Both set CY to the carry out of bit 7, AC to the carry out of bit 3, and OV to the signed two's-complement overflow.
- R5: Opcode 3 computes A-operand-CY. It sets CY to the borrow out of bit 7, AC to the borrow out of bit 3, and OV to the signed overflow. Opcode 9 (compare) sets CY when A < operand unsigned and changes nothing else.
- R6: Opcodes 4 and 5 add 1 to and subtract 1 from A, wrapping modulo 256, and leave psw bits 7:1 unchanged.
- R7: Opcode 6 multiplies A by B unsigned. The low product byte goes to A and the high byte to B. CY is cleared, and OV is set exactly when the product exceeds 255.
- R8: Opcode 7 divides A by B unsigned, putting the quotient in A and the remainder in B, with CY and OV cleared. When B is 0, OV is set, CY is cleared, and A and B are kept.
- R9: Opcode 8 (decimal adjust) adds 06h when the low nibble is above 9 or AC is set. It then adds 60h when the high nibble is above 9 or CY is set. A carry out of either addition sets CY, which is otherwise unchanged.
- R10: Opcodes 10, 11 and 12 put A AND, OR and XOR operand into A. Opcode 13 complements A. All four leave psw bits 7:1 unchanged.
- R11: Opcodes 14 and 15 rotate A left and right without carry. Opcodes 16 and 17 rotate left and right through CY. Opcode 18 swaps the two nibbles of A.
- R12: Opcodes 19, 20 and 21 set, clear and complement CY. Opcodes 22 and 23 AND CY with bit_in and with its complement. Opcodes 24 and 25 OR CY with bit_in and with its complement. Opcode 26 copies bit_in into CY.
- R13: Opcode 27 loads A from the operand and opcode 28 loads B. Opcode 0, opcodes 30 and 31, and any cycle with op_valid low leave acc, b_reg and psw unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Apply op_code this cycle |
| op_code | input | 5 | Operation select |
| operand | input | 8 | Second byte operand or status-word load value |
| bit_in | input | 1 | Boolean operand bit |
| acc | output | 8 | Accumulator |
| b_reg | output | 8 | B register |
| psw | output | 8 | Status word CY AC F0 RS1 RS0 OV F1 P |
| bank_base | output | BANK_ADDR_W (8) | Register-bank base address |

## Verification
The decimal-adjust corner cases are the hardest to reach. They need a particular AC and CY left behind by an earlier addition, together with a given accumulator value. The stimulus gets there by loading A, running a real add so the flags come out of the block's own arithmetic, and then issuing the adjust. This covers both the low-nibble-carry path and the high-correction path that overflows past FFh. Divide by zero and each of the four bank codes are driven directly. A long random run then mixes every opcode, including unused codes and idle cycles. A behavioural model predicts all outputs and is compared after every edge.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

   localparam int BYTE_W = 8;
   localparam int OPC_W  = 5;

   typedef enum logic [OPC_W-1:0] {
      OP_NOP   = 5'd0,
      OP_ADD   = 5'd1,
      OP_ADDC  = 5'd2,
      OP_SUBB  = 5'd3,
      OP_INC   = 5'd4,
      OP_DEC   = 5'd5,
      OP_MUL   = 5'd6,
      OP_DIV   = 5'd7,
      OP_DADJ  = 5'd8,
      OP_CMP   = 5'd9,
      OP_AND   = 5'd10,
      OP_OR    = 5'd11,
      OP_XOR   = 5'd12,
      OP_CPL   = 5'd13,
      OP_ROL   = 5'd14,
      OP_ROR   = 5'd15,
      OP_ROLC  = 5'd16,
      OP_RORC  = 5'd17,
      OP_SWAP  = 5'd18,
      OP_SETC  = 5'd19,
      OP_CLRC  = 5'd20,
      OP_CPLC  = 5'd21,
      OP_ANDC  = 5'd22,
      OP_ANDNC = 5'd23,
      OP_ORC   = 5'd24,
      OP_ORNC  = 5'd25,
      OP_MOVC  = 5'd26,
      OP_LDA   = 5'd27,
      OP_LDB   = 5'd28,
      OP_LDSW  = 5'd29
   } alu_op_e;

   // status word bit positions (decoded by neighbours, keep fixed)
   localparam int SW_CY  = 7;
   localparam int SW_AC  = 6;
   localparam int SW_RS1 = 4;
   localparam int SW_RS0 = 3;
   localparam int SW_OV  = 2;
   localparam int SW_P   = 0;

   typedef struct packed {
      logic we;
      logic val;
   } flag_upd_t;

   typedef struct packed {
      logic              we_a;
      logic [BYTE_W-1:0] a;
      logic              we_b;
      logic [BYTE_W-1:0] b;
      flag_upd_t         cy;
      flag_upd_t         ac;
      flag_upd_t         ov;
   } alu_upd_t;

endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith
   import acc_alu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  alu_op_e           op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic [DATA_W-1:0] opd,
   input  logic              cy,
   input  logic              ac,
   output alu_upd_t          upd
);
   localparam int HALF = DATA_W / 2;
   localparam int PW   = 2 * DATA_W;

   logic [DATA_W:0]   s9;
   logic [HALF:0]     n5;
   logic [PW-1:0]     prod;
   logic [DATA_W:0]   t1;
   logic [DATA_W:0]   t2;
   logic              c1;
   logic              cin;

   always_comb begin
      upd  = '0;
      s9   = '0;
      n5   = '0;
      prod = '0;
      t1   = '0;
      t2   = '0;
      c1   = 1'b0;
      cin  = (op == OP_ADD) ? 1'b0 : cy;
      unique case (op)
         OP_ADD, OP_ADDC: begin
            s9 = {1'b0, a} + {1'b0, opd} + {{DATA_W{1'b0}}, cin};
            n5 = {1'b0, a[HALF-1:0]} + {1'b0, opd[HALF-1:0]} + {{HALF{1'b0}}, cin};
            upd.we_a   = 1'b1;
            upd.a      = s9[DATA_W-1:0];
            upd.cy.we  = 1'b1;
            upd.cy.val = s9[DATA_W];
            upd.ac.we  = 1'b1;
            upd.ac.val = n5[HALF];
            upd.ov.we  = 1'b1;
            upd.ov.val = (a[DATA_W-1] == opd[DATA_W-1]) && (s9[DATA_W-1] != a[DATA_W-1]);
         end
         OP_SUBB: begin
            s9 = {1'b0, a} - {1'b0, opd} - {{DATA_W{1'b0}}, cy};
            n5 = {1'b0, a[HALF-1:0]} - {1'b0, opd[HALF-1:0]} - {{HALF{1'b0}}, cy};
            upd.we_a   = 1'b1;
            upd.a      = s9[DATA_W-1:0];
            upd.cy.we  = 1'b1;
            upd.cy.val = s9[DATA_W];
            upd.ac.we  = 1'b1;
            upd.ac.val = n5[HALF];
            upd.ov.we  = 1'b1;
            upd.ov.val = (a[DATA_W-1] != opd[DATA_W-1]) && (s9[DATA_W-1] != a[DATA_W-1]);
         end
         OP_CMP: begin
            upd.cy.we  = 1'b1;
            upd.cy.val = (a < opd);
         end
         OP_INC: begin
            upd.we_a = 1'b1;
            upd.a    = a + DATA_W'(1);
         end
         OP_DEC: begin
            upd.we_a = 1'b1;
            upd.a    = a - DATA_W'(1);
         end
         OP_MUL: begin
            prod       = {{DATA_W{1'b0}}, a} * {{DATA_W{1'b0}}, b};
            upd.we_a   = 1'b1;
            upd.a      = prod[DATA_W-1:0];
            upd.we_b   = 1'b1;
            upd.b      = prod[PW-1:DATA_W];
            upd.cy.we  = 1'b1;
            upd.cy.val = 1'b0;
            upd.ov.we  = 1'b1;
            upd.ov.val = |prod[PW-1:DATA_W];
         end
         OP_DIV: begin
            upd.cy.we = 1'b1;
            upd.ov.we = 1'b1;
            if (b == '0) begin
               upd.ov.val = 1'b1;
            end else begin
               upd.we_a = 1'b1;
               upd.a    = a / b;
               upd.we_b = 1'b1;
               upd.b    = a % b;
            end
         end
         OP_DADJ: begin
            t1 = {1'b0, a};
            if ((a[HALF-1:0] > HALF'(9)) || ac)
               t1 = {1'b0, a} + (DATA_W+1)'(6);
            c1 = t1[DATA_W] | cy;
            t2 = {1'b0, t1[DATA_W-1:0]};
            if ((t1[DATA_W-1:HALF] > HALF'(9)) || c1)
               t2 = {1'b0, t1[DATA_W-1:0]} + {1'b0, HALF'(6), HALF'(0)};
            upd.we_a   = 1'b1;
            upd.a      = t2[DATA_W-1:0];
            upd.cy.we  = 1'b1;
            upd.cy.val = c1 | t2[DATA_W];
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
   import acc_alu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  alu_op_e           op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] opd,
   input  logic              cy,
   output alu_upd_t          upd
);
   localparam int HALF = DATA_W / 2;

   always_comb begin
      upd = '0;
      unique case (op)
         OP_AND:  begin upd.we_a = 1'b1; upd.a = a & opd; end
         OP_OR:   begin upd.we_a = 1'b1; upd.a = a | opd; end
         OP_XOR:  begin upd.we_a = 1'b1; upd.a = a ^ opd; end
         OP_CPL:  begin upd.we_a = 1'b1; upd.a = ~a; end
         OP_ROL:  begin upd.we_a = 1'b1; upd.a = {a[DATA_W-2:0], a[DATA_W-1]}; end
         OP_ROR:  begin upd.we_a = 1'b1; upd.a = {a[0], a[DATA_W-1:1]}; end
         OP_ROLC: begin
            upd.we_a   = 1'b1;
            upd.a      = {a[DATA_W-2:0], cy};
            upd.cy.we  = 1'b1;
            upd.cy.val = a[DATA_W-1];
         end
         OP_RORC: begin
            upd.we_a   = 1'b1;
            upd.a      = {cy, a[DATA_W-1:1]};
            upd.cy.we  = 1'b1;
            upd.cy.val = a[0];
         end
         OP_SWAP: begin upd.we_a = 1'b1; upd.a = {a[HALF-1:0], a[DATA_W-1:HALF]}; end
         OP_LDA:  begin upd.we_a = 1'b1; upd.a = opd; end
         OP_LDB:  begin upd.we_b = 1'b1; upd.b = opd; end
         default: ;
      endcase
   end

endmodule

// File: rtl/acc_alu_bitop.sv
module acc_alu_bitop
   import acc_alu_pkg::*;
(
   input  alu_op_e  op,
   input  logic     cy,
   input  logic     bit_in,
   output alu_upd_t upd
);
   always_comb begin
      upd = '0;
      upd.cy.we = 1'b1;
      unique case (op)
         OP_SETC:  upd.cy.val = 1'b1;
         OP_CLRC:  upd.cy.val = 1'b0;
         OP_CPLC:  upd.cy.val = ~cy;
         OP_ANDC:  upd.cy.val = cy & bit_in;
         OP_ANDNC: upd.cy.val = cy & ~bit_in;
         OP_ORC:   upd.cy.val = cy | bit_in;
         OP_ORNC:  upd.cy.val = cy | ~bit_in;
         OP_MOVC:  upd.cy.val = bit_in;
         default:  upd.cy.we  = 1'b0;
      endcase
   end

endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
   import acc_alu_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int BANK_ADDR_W  = 8,
   parameter int BANK_STRIDE  = 8,
   parameter bit PARITY_CHAIN = 1'b0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   op_valid,
   input  logic [OPC_W-1:0]       op_code,
   input  logic [DATA_W-1:0]      operand,
   input  logic                   bit_in,
   output logic [DATA_W-1:0]      acc,
   output logic [DATA_W-1:0]      b_reg,
   output logic [DATA_W-1:0]      psw,
   output logic [BANK_ADDR_W-1:0] bank_base
);
   localparam int MAX_BASE = 3 * BANK_STRIDE;

   generate
      if (DATA_W != BYTE_W) begin : g_bad_width
         $error("acc_alu_core: DATA_W must equal the byte width");
      end
      if (MAX_BASE >= (1 << BANK_ADDR_W)) begin : g_bad_bank
         $error("acc_alu_core: BANK_ADDR_W too narrow for BANK_STRIDE");
      end
   endgenerate

   alu_op_e           op_e;
   alu_upd_t          u_ar, u_lg, u_bt, u_all;
   logic [DATA_W-1:0] a_q, b_q, sw_q;
   logic [DATA_W-1:0] a_nxt, b_nxt, sw_nxt;
   logic              par_nxt;

   assign op_e = alu_op_e'(op_code);

   acc_alu_arith #(.DATA_W(DATA_W)) u_arith (
      .op(op_e), .a(a_q), .b(b_q), .opd(operand),
      .cy(sw_q[SW_CY]), .ac(sw_q[SW_AC]), .upd(u_ar)
   );

   acc_alu_logic #(.DATA_W(DATA_W)) u_logic (
      .op(op_e), .a(a_q), .opd(operand), .cy(sw_q[SW_CY]), .upd(u_lg)
   );

   acc_alu_bitop u_bitop (
      .op(op_e), .cy(sw_q[SW_CY]), .bit_in(bit_in), .upd(u_bt)
   );

   // units decode disjoint opcodes and drive zero otherwise
   assign u_all = u_ar | u_lg | u_bt;

   assign a_nxt = u_all.we_a ? u_all.a : a_q;
   assign b_nxt = u_all.we_b ? u_all.b : b_q;

   generate
      if (PARITY_CHAIN) begin : g_par_chain
         logic [DATA_W:0] chain;
         assign chain[0] = 1'b0;
         for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            assign chain[i+1] = chain[i] ^ a_nxt[i];
         end
         assign par_nxt = chain[DATA_W];
      end else begin : g_par_reduce
         assign par_nxt = ^a_nxt;
      end
   endgenerate

   always_comb begin
      sw_nxt = sw_q;
      if (op_e == OP_LDSW) sw_nxt[DATA_W-1:1] = operand[DATA_W-1:1];
      if (u_all.cy.we) sw_nxt[SW_CY] = u_all.cy.val;
      if (u_all.ac.we) sw_nxt[SW_AC] = u_all.ac.val;
      if (u_all.ov.we) sw_nxt[SW_OV] = u_all.ov.val;
      sw_nxt[SW_P] = par_nxt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q  <= '0;
         b_q  <= '0;
         sw_q <= '0;
      end else if (op_valid) begin
         a_q  <= a_nxt;
         b_q  <= b_nxt;
         sw_q <= sw_nxt;
      end
   end

   assign acc       = a_q;
   assign b_reg     = b_q;
   assign psw       = sw_q;
   assign bank_base = BANK_ADDR_W'({sw_q[SW_RS1], sw_q[SW_RS0]}) * BANK_ADDR_W'(BANK_STRIDE);

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
   import acc_alu_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int BANK_ADDR_W = 8,
   parameter int BANK_STRIDE = 8
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   op_valid,
   input logic [OPC_W-1:0]       op_code,
   input logic [DATA_W-1:0]      operand,
   input logic [DATA_W-1:0]      acc,
   input logic [DATA_W-1:0]      b_reg,
   input logic [DATA_W-1:0]      psw,
   input logic [BANK_ADDR_W-1:0] bank_base
);
   logic is_logic;
   assign is_logic = (op_code == OP_AND) || (op_code == OP_OR) ||
                     (op_code == OP_XOR) || (op_code == OP_CPL);

   AST_RESET_CLEAR: assert property (@(posedge clk)
      !rst_n |=> (acc == '0 && b_reg == '0 && psw == '0)); // R1

   AST_PARITY_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
      psw[SW_P] == ^acc); // R2

   AST_BANK_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OP_LDSW) |=>
      bank_base == BANK_ADDR_W'(int'($past(operand[SW_RS1:SW_RS0])) * BANK_STRIDE)); // R3

   AST_INCDEC_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && (op_code == OP_INC || op_code == OP_DEC)) |=>
      psw[DATA_W-1:1] == $past(psw[DATA_W-1:1])); // R6

   AST_MUL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OP_MUL) |=>
      (!psw[SW_CY] && (psw[SW_OV] == (b_reg != '0)))); // R7

   AST_DIV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OP_DIV && b_reg == '0) |=>
      (psw[SW_OV] && !psw[SW_CY] && $stable(acc) && $stable(b_reg))); // R8

   AST_LOGIC_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && is_logic) |=> psw[DATA_W-1:1] == $past(psw[DATA_W-1:1])); // R10

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> ($stable(acc) && $stable(b_reg) && $stable(psw))); // R13

endmodule

bind acc_alu_core acc_alu_chk #(
   .DATA_W(DATA_W), .BANK_ADDR_W(BANK_ADDR_W), .BANK_STRIDE(BANK_STRIDE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
   .operand(operand), .acc(acc), .b_reg(b_reg), .psw(psw), .bank_base(bank_base)
);

// File: tb/tb_acc_alu_core.sv
`timescale 1ns/1ps
module tb_acc_alu_core;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_valid = 1'b0;
   logic [4:0] op_code = '0;
   logic [7:0] operand = '0;
   logic       bit_in = 1'b0;
   logic [7:0] acc, b_reg, psw, bank_base;

   int total = 0;
   int fails = 0;
   bit done = 0;

   // reference state
   int ma = 0, mb = 0;
   int mcy = 0, mac = 0, mf0 = 0, mrs = 0, mov = 0, mf1 = 0;

   always #5 clk = ~clk;

   acc_alu_core dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .operand(operand), .bit_in(bit_in), .acc(acc), .b_reg(b_reg),
      .psw(psw), .bank_base(bank_base)
   );

   function automatic int ones(input int v);
      int n = 0;
      for (int i = 0; i < 8; i++) n += (v >> i) & 1;
      return n;
   endfunction

   function automatic string tag_of(input bit v, input int o);
      if (!v) return "R13";
      case (o)
         1, 2: return "R4";
         3, 9: return "R5";
         4, 5: return "R6";
         6: return "R7";
         7: return "R8";
         8: return "R9";
         10, 11, 12, 13: return "R10";
         14, 15, 16, 17, 18: return "R11";
         19, 20, 21, 22, 23, 24, 25, 26: return "R12";
         29: return "R3";
         default: return "R13";
      endcase
   endfunction

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic model(input bit v, input int o, input int d, input int bt);
      int s, sa, sd, ss, p;
      if (!v) return;
      sa = (ma > 127) ? ma - 256 : ma;
      sd = (d > 127) ? d - 256 : d;
      case (o)
         1, 2: begin
            s = (o == 2) ? mcy : 0;
            mac = (((ma & 15) + (d & 15) + s) > 15) ? 1 : 0;
            ss = sa + sd + s;
            mov = (ss > 127 || ss < -128) ? 1 : 0;
            s = ma + d + s;
            mcy = (s > 255) ? 1 : 0;
            ma = s & 255;
         end
         3: begin
            mac = (((ma & 15) - (d & 15) - mcy) < 0) ? 1 : 0;
            ss = sa - sd - mcy;
            mov = (ss > 127 || ss < -128) ? 1 : 0;
            s = ma - d - mcy;
            mcy = (s < 0) ? 1 : 0;
            ma = (s + 256) & 255;
         end
         4: ma = (ma + 1) % 256;
         5: ma = (ma + 255) % 256;
         6: begin p = ma * mb; ma = p % 256; mb = p / 256; mcy = 0; mov = (p > 255) ? 1 : 0; end
         7: begin
            mcy = 0;
            if (mb == 0) mov = 1;
            else begin p = ma; ma = p / mb; mb = p % mb; mov = 0; end
         end
         8: begin
            if ((ma % 16) > 9 || mac == 1) begin ma += 6; if (ma > 255) mcy = 1; ma %= 256; end
            if ((ma / 16) > 9 || mcy == 1) begin ma += 96; if (ma > 255) mcy = 1; ma %= 256; end
         end
         9: mcy = (ma < d) ? 1 : 0;
         10: ma = ma & d;
         11: ma = ma | d;
         12: ma = ma ^ d;
         13: ma = 255 - ma;
         14: ma = ((ma * 2) % 256) + (ma / 128);
         15: ma = (ma / 2) + (ma % 2) * 128;
         16: begin s = ma / 128; ma = ((ma * 2) % 256) + mcy; mcy = s; end
         17: begin s = ma % 2; ma = (ma / 2) + mcy * 128; mcy = s; end
         18: ma = (ma % 16) * 16 + ma / 16;
         19: mcy = 1;
         20: mcy = 0;
         21: mcy = 1 - mcy;
         22: mcy = mcy & bt;
         23: mcy = mcy & (1 - bt);
         24: mcy = mcy | bt;
         25: mcy = mcy | (1 - bt);
         26: mcy = bt;
         27: ma = d;
         28: mb = d;
         29: begin
            mcy = (d >> 7) & 1; mac = (d >> 6) & 1; mf0 = (d >> 5) & 1;
            mrs = (d >> 3) & 3; mov = (d >> 2) & 1; mf1 = (d >> 1) & 1;
         end
         default: ;
      endcase
   endtask

   task automatic compare(input string tag);
      int ep;
      ep = mcy * 128 + mac * 64 + mf0 * 32 + mrs * 8 + mov * 4 + mf1 * 2 + (ones(ma) % 2);
      check(acc == 8'(ma), tag, "acc", acc, ma);
      check(b_reg == 8'(mb), tag, "b_reg", b_reg, mb);
      check(psw[7:1] == 7'(ep >> 1), tag, "psw[7:1]", psw[7:1], ep >> 1);
      check(psw[0] == 1'(ep & 1), "R2", "parity", psw[0], ep & 1);
      check(bank_base == 8'(mrs * 8), "R3", "bank_base", bank_base, mrs * 8);
   endtask

   task automatic step(input bit v, input int o, input int d, input int bt);
      op_valid = v;
      op_code  = 5'(o);
      operand  = 8'(d);
      bit_in   = 1'(bt);
      model(v, o, d, bt);
      @(negedge clk);
      compare(tag_of(v, o));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check(acc == 8'h00 && b_reg == 8'h00, "R1", "acc/b in reset", {acc, b_reg}, 0);
      check(psw == 8'h00 && bank_base == 8'h00, "R1", "psw/bank in reset", {psw, bank_base}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1");

      // R4 add: 3A+C6 -> 00, CY=1 AC=1 OV=0
      step(1, 27, 8'h3A, 0);
      step(1, 1, 8'hC6, 0);
      // signed overflow 7F+01
      step(1, 27, 8'h7F, 0);
      step(1, 1, 8'h01, 0);
      step(1, 19, 0, 0);
      step(1, 2, 8'h10, 0);
      // R5 subtract with borrow and compare
      step(1, 27, 8'h80, 0);
      step(1, 19, 0, 0);
      step(1, 3, 8'h01, 0);
      step(1, 27, 8'h00, 0);
      step(1, 3, 8'hFF, 0);
      step(1, 9, 8'h05, 0);
      step(1, 9, 8'hF0, 0);
      // R6 wrap
      step(1, 27, 8'hFF, 0);
      step(1, 4, 0, 0);
      step(1, 5, 0, 0);
      // R7 multiply, with and without overflow
      step(1, 28, 8'h40, 0);
      step(1, 27, 8'h08, 0);
      step(1, 6, 0, 0);
      step(1, 28, 8'h05, 0);
      step(1, 27, 8'h07, 0);
      step(1, 6, 0, 0);
      // R8 divide and divide by zero
      step(1, 27, 8'hFB, 0);
      step(1, 28, 8'h10, 0);
      step(1, 7, 0, 0);
      step(1, 28, 8'h00, 0);
      step(1, 7, 0, 0);
      // R9 decimal adjust: 38+29 -> 67 with AC, then 99+99 -> 98 with CY
      step(1, 20, 0, 0);
      step(1, 27, 8'h38, 0);
      step(1, 1, 8'h29, 0);
      step(1, 8, 0, 0);
      step(1, 27, 8'h99, 0);
      step(1, 1, 8'h99, 0);
      step(1, 8, 0, 0);
      step(1, 27, 8'h9A, 0);
      step(1, 20, 0, 0);
      step(1, 8, 0, 0);
      // R10 logic, R11 rotate/swap
      step(1, 10, 8'h0F, 0);
      step(1, 11, 8'hA0, 0);
      step(1, 12, 8'hFF, 0);
      step(1, 13, 0, 0);
      step(1, 27, 8'h81, 0);
      step(1, 14, 0, 0);
      step(1, 15, 0, 0);
      step(1, 20, 0, 0);
      step(1, 16, 0, 0);
      step(1, 17, 0, 0);
      step(1, 18, 0, 0);
      // R12 Boolean carry
      for (int o = 19; o <= 26; o++) begin
         step(1, 19, 0, 0); step(1, o, 0, 0); step(1, o, 0, 1);
         step(1, 20, 0, 0); step(1, o, 0, 1); step(1, o, 0, 0);
      end
      // R3 every bank code
      for (int r = 0; r < 4; r++) step(1, 29, r * 8 + 8'hA6, 0);
      // R13 idle, NOP, unused codes
      step(0, 1, 8'h55, 1);
      step(1, 0, 8'h55, 1);
      step(1, 30, 8'h55, 1);
      step(1, 31, 8'h55, 1);
      // random mix
      for (int i = 0; i < 4000; i++)
         step(($urandom % 8) != 0, $urandom % 32, $urandom % 256, $urandom % 2);
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         fails++;
         $display("FAIL watchdog run did not complete actual=0 expected=1");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

endmodule